// File: doc/BRIEF.md
# Carry-Lookahead Adder/Subtractor

This block adds or subtracts two unsigned or two's-complement operands in one combinational pass. The operand width is split into 4-bit groups. Inside each group every carry is formed directly from per-bit generate and propagate terms and the group's incoming carry, as a flat two-level AND-OR expression, so no carry within a group waits on a lower carry. Groups are joined in a chain: the carry leaving one group is the carry entering the next. Each group also reports a group generate and a group propagate bit, so a surrounding design can build its own lookahead across groups.

A mode input selects subtraction. In that mode the second operand is bit-inverted and the carry into bit 0 is forced high, so the same adder computes A minus B in two's complement. The external carry input is then unused. The carry output in subtract mode means "no borrow". A signed overflow flag is formed from the carry into and the carry out of the most significant bit.

Top module: `cla_addsub`

## Requirements
- R1: With `subtract`=0, `{carry_out, result}` equals `op_a + op_b + carry_in` taken as unsigned numbers.
- R2: With `subtract`=1, `result` equals `op_a - op_b` modulo 2^WIDTH, and `carry_in` has no effect on any output.
- R3: With `subtract`=1, `carry_out` is 1 exactly when `op_a >= op_b` as unsigned numbers, meaning no borrow.
- R4: `overflow` is 1 exactly when the signed two's-complement result of the selected operation, `op_a + op_b + carry_in` or `op_a - op_b`, lies outside the signed WIDTH-bit range.
- R5: Bit k of `grp_generate` is 1 exactly when bits 4k+3..4k of `op_a` plus the same bits of the effective second operand (`op_b` when adding, `~op_b` when subtracting) is at least 16, so the group produces a carry whatever carry enters it.
- R6: Bit k of `grp_propagate` is the AND, over bits 4k+3..4k, of the OR of `op_a` and the effective second operand.
- R7: A carry travels through every group in the chain: with `op_a` all ones, `op_b` zero and `carry_in`=1 in add mode, `result` is zero and `carry_out` is 1.
- R8: With all inputs zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 when adding |
| subtract | input | 1 | 1 selects op_a - op_b |
| result | output | WIDTH | Sum or difference |
| carry_out | output | 1 | Carry out of the top bit; in subtract mode 1 means no borrow |
| overflow | output | 1 | Signed overflow of the selected operation |
| grp_generate | output | WIDTH/4 | Per-group generate |
| grp_propagate | output | WIDTH/4 | Per-group propagate |

## Verification
The assertions assume WIDTH is a multiple of four and that inputs change only between checks, so the combinational outputs have settled when the checker evaluates them; they also assume the inputs carry no unknown bits. The bench drives every input to a known value right after a rising clock edge and reads outputs at the following falling edge, never leaving an input undriven. Random operands are drawn for both modes and both carry-in values, and directed cases put the all-ones, zero and sign-boundary operands through every group.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned GROUP_BITS = 4;

  typedef logic [GROUP_BITS-1:0] grp_vec_t;
  typedef logic [GROUP_BITS:0]   grp_carry_t;

  // Per-bit generate: both inputs high.
  function automatic grp_vec_t bit_generate(input grp_vec_t x, input grp_vec_t y);
    return x & y;
  endfunction

  // Per-bit propagate: either input high.
  function automatic grp_vec_t bit_propagate(input grp_vec_t x, input grp_vec_t y);
    return x | y;
  endfunction

  // Every carry of the group as a flat sum of products of g, p and c0.
  function automatic grp_carry_t lookahead_carries(input grp_vec_t g,
                                                   input grp_vec_t p,
                                                   input logic     c0);
    grp_carry_t c;
    logic       term;
    c    = '0;
    c[0] = c0;
    for (int k = 1; k <= GROUP_BITS; k++) begin
      for (int j = 0; j < k; j++) begin
        term = g[j];
        for (int m = j + 1; m < k; m++) term = term & p[m];
        c[k] = c[k] | term;
      end
      term = c0;
      for (int m = 0; m < k; m++) term = term & p[m];
      c[k] = c[k] | term;
    end
    return c;
  endfunction

  // Group generate: a carry leaves the group independent of its carry-in.
  function automatic logic group_generate(input grp_vec_t g, input grp_vec_t p);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < GROUP_BITS; j++) begin
      term = g[j];
      for (int m = j + 1; m < GROUP_BITS; m++) term = term & p[m];
      acc = acc | term;
    end
    return acc;
  endfunction

  // Group propagate: every bit passes an incoming carry.
  function automatic logic group_propagate(input grp_vec_t p);
    return &p;
  endfunction

  // Sum bits from the half-sum and the carries into each bit.
  function automatic grp_vec_t group_sum(input grp_vec_t x, input grp_vec_t y,
                                         input grp_carry_t c);
    return x ^ y ^ c[GROUP_BITS-1:0];
  endfunction

endpackage

// File: rtl/cla_operand_prep.sv
module cla_operand_prep #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] b_raw,
  input  logic             carry_raw,
  input  logic             subtract,
  output logic [WIDTH-1:0] b_eff,
  output logic             carry_zero
);

  // Two's complement subtraction: invert B and inject a one at bit 0.
  always_comb begin
    b_eff      = subtract ? ~b_raw : b_raw;
    carry_zero = subtract ? 1'b1   : carry_raw;
  end

endmodule

// File: rtl/cla_group4.sv
module cla_group4
  import cla_pkg::*;
(
  input  grp_vec_t x,
  input  grp_vec_t y,
  input  logic     c_in,
  output grp_vec_t sum,
  output logic     c_out,
  output logic     c_top_in,
  output logic     g_grp,
  output logic     p_grp
);

  grp_vec_t   gen_bits;
  grp_vec_t   prop_bits;
  grp_carry_t carries;

  always_comb begin
    gen_bits  = bit_generate(x, y);
    prop_bits = bit_propagate(x, y);
    carries   = lookahead_carries(gen_bits, prop_bits, c_in);
    sum       = group_sum(x, y, carries);
    c_out     = carries[GROUP_BITS];
    c_top_in  = carries[GROUP_BITS-1];
    g_grp     = group_generate(gen_bits, prop_bits);
    p_grp     = group_propagate(prop_bits);
  end

endmodule

// File: rtl/cla_chain.sv
module cla_chain
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0]            x,
  input  logic [WIDTH-1:0]            y,
  input  logic                        c0,
  output logic [WIDTH-1:0]            sum,
  output logic                        c_final,
  output logic                        c_into_msb,
  output logic [WIDTH/GROUP_BITS-1:0] g_vec,
  output logic [WIDTH/GROUP_BITS-1:0] p_vec,
  output logic [WIDTH/GROUP_BITS:0]   grp_carry
);

  localparam int unsigned GROUPS = WIDTH / GROUP_BITS;

  logic [GROUPS-1:0] top_in;

  assign grp_carry[0] = c0;

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_grp
    cla_group4 u_grp (
      .x        (x[gi*GROUP_BITS +: GROUP_BITS]),
      .y        (y[gi*GROUP_BITS +: GROUP_BITS]),
      .c_in     (grp_carry[gi]),
      .sum      (sum[gi*GROUP_BITS +: GROUP_BITS]),
      .c_out    (grp_carry[gi+1]),
      .c_top_in (top_in[gi]),
      .g_grp    (g_vec[gi]),
      .p_grp    (p_vec[gi])
    );
  end

  assign c_final    = grp_carry[GROUPS];
  assign c_into_msb = top_in[GROUPS-1];

endmodule

// File: rtl/cla_addsub.sv
module cla_addsub #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  input  logic               carry_in,
  input  logic               subtract,
  output logic [WIDTH-1:0]   result,
  output logic               carry_out,
  output logic               overflow,
  output logic [WIDTH/4-1:0] grp_generate,
  output logic [WIDTH/4-1:0] grp_propagate
);

  localparam int unsigned GROUPS = WIDTH / cla_pkg::GROUP_BITS;

  // Named internal events for the checker.
  logic [WIDTH-1:0] operand_eff;
  logic             carry_zero;
  logic             carry_into_msb;
  logic [GROUPS:0]  group_carry;

  cla_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b_raw      (op_b),
    .carry_raw  (carry_in),
    .subtract   (subtract),
    .b_eff      (operand_eff),
    .carry_zero (carry_zero)
  );

  cla_chain #(.WIDTH(WIDTH)) u_chain (
    .x          (op_a),
    .y          (operand_eff),
    .c0         (carry_zero),
    .sum        (result),
    .c_final    (carry_out),
    .c_into_msb (carry_into_msb),
    .g_vec      (grp_generate),
    .p_vec      (grp_propagate),
    .grp_carry  (group_carry)
  );

  assign overflow = carry_into_msb ^ carry_out;

endmodule

// File: rtl/cla_addsub_checker.sv
module cla_addsub_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic               carry_in,
  input logic               subtract,
  input logic [WIDTH-1:0]   result,
  input logic               carry_out,
  input logic               overflow,
  input logic [WIDTH/4-1:0] grp_generate,
  input logic [WIDTH/4-1:0] grp_propagate,
  input logic [WIDTH-1:0]   operand_eff,
  input logic               carry_zero,
  input logic [WIDTH/4:0]   group_carry
);

  localparam int unsigned GROUPS = WIDTH / 4;

  logic [WIDTH:0] arith_total;
  logic           sign_match;

  always_comb begin
    arith_total = {1'b0, op_a} + {1'b0, operand_eff} + {{WIDTH{1'b0}}, carry_zero};
    sign_match  = (op_a[WIDTH-1] == operand_eff[WIDTH-1]);

    // R1 / R2: adder output matches arithmetic on the prepared operands
    assert_sum_R1: assert ({carry_out, result} == arith_total);
    // R2: subtract forces carry into bit 0
    if (subtract) assert_sub_cin_R2: assert (carry_zero == 1'b1);
    // R3: no borrow flag in subtract mode
    if (subtract) assert_borrow_R3: assert (carry_out == (op_a >= op_b));
    // R4: overflow only when like-signed operands give an unlike-signed result
    assert_overflow_R4: assert (overflow == (sign_match && (result[WIDTH-1] != op_a[WIDTH-1])));
    for (int k = 0; k < GROUPS; k++) begin
      // R5: a generating group always emits a carry
      if (grp_generate[k]) assert_gen_carry_R5: assert (group_carry[k+1]);
      // R6: a group neither generating nor propagating kills the carry
      if (!grp_generate[k] && !grp_propagate[k]) assert_kill_R6: assert (!group_carry[k+1]);
      // R7: a propagating, non-generating group passes its carry-in
      if (grp_propagate[k] && !grp_generate[k]) assert_pass_R7: assert (group_carry[k+1] == group_carry[k]);
    end
  end

endmodule

bind cla_addsub cla_addsub_checker #(.WIDTH(WIDTH)) u_checker (
  .op_a          (op_a),
  .op_b          (op_b),
  .carry_in      (carry_in),
  .subtract      (subtract),
  .result        (result),
  .carry_out     (carry_out),
  .overflow      (overflow),
  .grp_generate  (grp_generate),
  .grp_propagate (grp_propagate),
  .operand_eff   (operand_eff),
  .carry_zero    (carry_zero),
  .group_carry   (group_carry)
);

// File: tb/test_cla_addsub.sv
module test_cla_addsub;

  localparam int W = 16;
  localparam int G = W / 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic         subtract = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         overflow;
  logic [G-1:0] grp_generate;
  logic [G-1:0] grp_propagate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cla_addsub #(.WIDTH(W)) i_cla_addsub (
    .op_a          (op_a),
    .op_b          (op_b),
    .carry_in      (carry_in),
    .subtract      (subtract),
    .result        (result),
    .carry_out     (carry_out),
    .overflow      (overflow),
    .grp_generate  (grp_generate),
    .grp_propagate (grp_propagate)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input logic sub);
    @(posedge clk);
    op_a <= a; op_b <= b; carry_in <= ci; subtract <= sub;
    @(negedge clk);
  endtask

  // Independent model: integer arithmetic on the port values.
  task automatic check_all(input string req);
    longint ua, ub, total;
    int     sa, sb, sres;
    logic [W-1:0] beff;
    longint exp_res, exp_cout, exp_ovf;
    ua = longint'(op_a); ub = longint'(op_b);
    sa = int'($signed(op_a)); sb = int'($signed(op_b));
    if (subtract) begin
      total    = ua - ub;
      exp_res  = total & 64'hFFFF;
      exp_cout = (ua >= ub) ? 1 : 0;
      sres     = sa - sb;
      beff     = ~op_b;
    end else begin
      total    = ua + ub + longint'(carry_in);
      exp_res  = total & 64'hFFFF;
      exp_cout = (total > 64'hFFFF) ? 1 : 0;
      sres     = sa + sb + int'(carry_in);
      beff     = op_b;
    end
    exp_ovf = (sres > 32767 || sres < -32768) ? 1 : 0;
    check(subtract ? "R2" : "R1", {req, " result"}, longint'(result), exp_res);
    check(subtract ? "R3" : "R1", {req, " carry_out"}, longint'(carry_out), exp_cout);
    check("R4", {req, " overflow"}, longint'(overflow), exp_ovf);
    for (int k = 0; k < G; k++) begin
      int sa4, sb4;
      sa4 = int'(op_a[k*4 +: 4]);
      sb4 = int'(beff[k*4 +: 4]);
      check("R5", {req, " grp_generate"}, longint'(grp_generate[k]),
            (sa4 + sb4 >= 16) ? 1 : 0);
      check("R6", {req, " grp_propagate"}, longint'(grp_propagate[k]),
            longint'(&(op_a[k*4 +: 4] | beff[k*4 +: 4])));
    end
  endtask

  task automatic t_zero_state;  // R8
    apply('0, '0, 1'b0, 1'b0);
    check("R8", "zero result", longint'(result), 0);
    check("R8", "zero carry_out", longint'(carry_out), 0);
    check("R8", "zero overflow", longint'(overflow), 0);
    check("R8", "zero generate", longint'(grp_generate), 0);
    check("R8", "zero propagate", longint'(grp_propagate), 0);
  endtask

  task automatic t_add_directed;  // R1
    apply(16'h1234, 16'h4321, 1'b0, 1'b0); check_all("add plain");
    apply(16'h00FF, 16'h0001, 1'b1, 1'b0); check_all("add cin");
    apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b0); check_all("add max");
    apply(16'h0F0F, 16'hF0F0, 1'b0, 1'b0); check_all("add alt");
  endtask

  task automatic t_chain;  // R7
    apply(16'hFFFF, 16'h0000, 1'b1, 1'b0);
    check("R7", "ripple result", longint'(result), 0);
    check("R7", "ripple carry_out", longint'(carry_out), 1);
    check("R7", "ripple propagate", longint'(grp_propagate), 64'hF);
  endtask

  task automatic t_sub_cin_ignored;  // R2
    logic [W-1:0] r0;
    logic c0_s, o0;
    apply(16'h5A5A, 16'h1234, 1'b0, 1'b1);
    r0 = result; c0_s = carry_out; o0 = overflow;
    apply(16'h5A5A, 16'h1234, 1'b1, 1'b1);
    check("R2", "cin ignored result", longint'(result), longint'(r0));
    check("R2", "cin ignored carry", longint'(carry_out), longint'(c0_s));
    check("R2", "cin ignored overflow", longint'(overflow), longint'(o0));
    check("R2", "difference", longint'(result), 64'h4826);
  endtask

  task automatic t_borrow;  // R3
    apply(16'h0003, 16'h0005, 1'b0, 1'b1); check_all("sub borrow");
    check("R3", "borrow flag", longint'(carry_out), 0);
    apply(16'h0005, 16'h0005, 1'b1, 1'b1); check_all("sub equal");
    check("R3", "equal no borrow", longint'(carry_out), 1);
    apply(16'h0000, 16'hFFFF, 1'b0, 1'b1); check_all("sub extreme");
  endtask

  task automatic t_overflow;  // R4
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0); check_all("add pos ovf");
    check("R4", "pos overflow", longint'(overflow), 1);
    apply(16'h8000, 16'hFFFF, 1'b0, 1'b0); check_all("add neg ovf");
    check("R4", "neg overflow", longint'(overflow), 1);
    apply(16'h8000, 16'h0001, 1'b0, 1'b1); check_all("sub ovf");
    check("R4", "sub overflow", longint'(overflow), 1);
    apply(16'h7FFE, 16'h0000, 1'b1, 1'b0); check_all("add edge no ovf");
    check("R4", "edge no overflow", longint'(overflow), 0);
  endtask

  task automatic t_random;  // R1..R6
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[15:0], r[31:16], i[0], i[1]);
      check_all("random");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_zero_state();
    t_add_directed();
    t_chain();
    t_sub_cin_ignored();
    t_borrow();
    t_overflow();
    t_random();
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule